// File: doc/BRIEF.md
# Two-Level Page Table Walker with Translation Cache

This block turns a 20-bit virtual address into a 20-bit physical address for a memory system built on 64 KB pages. The top four address bits form the virtual page number and the low sixteen bits pass through unchanged as the offset. A four-slot, fully associative translation cache is searched first. On a hit the result comes back on the next cycle and the memory port stays untouched.

On a miss, a small state machine walks a two-level page table held in memory. It reads one 32-bit word from the first-level table, which gives the base of a second-level table. It then reads one word from that second-level table, the leaf, which gives the physical frame number. Each read waits for its response before the walk goes on. The new mapping is placed in the cache. A free slot is taken if one exists; otherwise a rotating pointer chooses the slot to overwrite.

A client offers a request with `req_valid` while `req_ready` is high. The result appears as a one-cycle `xl_done` pulse with `xl_pa`.

Top module: `vm_xlate_walker`

## Requirements
- R1: After reset, `req_ready` is 1, `mem_req` is 0 and `xl_done` is 0. The cache holds no valid mapping, so the first request of any page performs a walk. The table base register resets to 0x01000.
- R2: The first read of a walk goes to address table_base + 4 × VA[19:18].
- R3: The second read goes to address L1[19:0] + 4 × VA[17:16], where L1 is the word returned by the first read. Bits 31:20 of that word are ignored.
- R4: The cycle after the leaf response, `xl_done` pulses with `xl_pa` = {leaf[19:16], VA[15:0]}.
- R5: While `mem_req` is high and no `mem_rvalid` arrives, `mem_req` stays high and `mem_addr` holds its value. A miss issues exactly two reads.
- R6: A request whose VA[19:16] matches a valid slot is answered with `xl_done` on the next cycle, from the cached frame number, with no memory read.
- R7: A new mapping fills an empty slot if any exists, so four distinct pages all stay resident and later requests to them all hit.
- R8: With every slot full, victims are chosen round-robin starting at slot 0. Each eviction advances the pointer; filling an empty slot does not.
- R9: `req_ready` is low for the whole walk. `req_valid` asserted during a walk is ignored.
- R10: Each accepted request produces exactly one `xl_done` pulse, and `xl_done` is only high while `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request offered |
| req_va | input | 20 | Virtual address to translate |
| req_ready | output | 1 | Idle; a request is accepted this cycle |
| mem_req | output | 1 | Table read outstanding |
| mem_addr | output | 20 | Physical byte address of the table word |
| mem_rvalid | input | 1 | Read data valid this cycle |
| mem_rdata | input | 32 | Read data word |
| xl_done | output | 1 | One-cycle translation complete strobe |
| xl_pa | output | 20 | Physical address, valid with `xl_done` |

## Verification
Two events can fall in the same cycle: a walk finishing and the next request being accepted. The completion pulse arrives exactly when the block becomes ready again, and that next request may hit the mapping that was just written. The bench provokes this by holding `req_valid` high through a stream of requests, so each new address is waiting while the previous walk runs. Some addresses in the stream repeat the page just fetched. A behavioural model predicts, on every clock, the ready, read and completion outputs, so a lost or doubled pulse or a stale lookup shows up in the cycle where it happens.

// File: rtl/vm_xlate_walker.sv
module vm_xlate_walker #(
  parameter logic [19:0] TABLE_BASE_RST = 20'h01000,
  parameter int          SLOTS          = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        req_valid,
  input  logic [19:0] req_va,
  output logic        req_ready,
  output logic        mem_req,
  output logic [19:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata,
  output logic        xl_done,
  output logic [19:0] xl_pa
);
  localparam int IW = (SLOTS > 1) ? $clog2(SLOTS) : 1;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_L1 = 2'd1, S_L2 = 2'd2} walk_t;

  walk_t            state;
  logic [19:0]      tbase;
  logic [19:0]      va_q;
  logic [19:0]      l2base_q;
  logic [3:0]       c_vpn [SLOTS];
  logic [3:0]       c_ppn [SLOTS];
  logic [SLOTS-1:0] c_val;
  logic [IW-1:0]    rr;

  logic [SLOTS-1:0] hit_vec;
  logic             hit_any;
  logic [3:0]       hit_ppn;
  logic             has_free;
  logic [IW-1:0]    free_idx;
  logic [IW-1:0]    victim;
  logic             accept;
  logic             leaf_fire;
  logic             unused_hi;

  genvar g;
  generate
    for (g = 0; g < SLOTS; g++) begin : g_cmp
      assign hit_vec[g] = c_val[g] && (c_vpn[g] == req_va[19:16]);
    end
  endgenerate

  always_comb begin
    hit_ppn = '0;
    for (int i = 0; i < SLOTS; i++)
      if (hit_vec[i]) hit_ppn = hit_ppn | c_ppn[i];
  end

  always_comb begin
    has_free = 1'b0;
    free_idx = '0;
    for (int i = SLOTS - 1; i >= 0; i--)
      if (!c_val[i]) begin
        has_free = 1'b1;
        free_idx = IW'(i);
      end
  end

  assign hit_any   = |hit_vec;
  assign victim    = has_free ? free_idx : rr;
  assign req_ready = (state == S_IDLE);
  assign accept    = req_ready && req_valid;
  assign leaf_fire = (state == S_L2) && mem_rvalid;
  assign mem_req   = (state != S_IDLE);
  assign mem_addr  = (state == S_L2) ? l2base_q + {16'b0, va_q[17:16], 2'b00}
                                     : tbase    + {16'b0, va_q[19:18], 2'b00};
  assign unused_hi = ^mem_rdata[31:20];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      tbase    <= TABLE_BASE_RST;
      va_q     <= '0;
      l2base_q <= '0;
    end else begin
      case (state)
        S_IDLE: if (accept && !hit_any) begin
          va_q  <= req_va;
          state <= S_L1;
        end
        S_L1: if (mem_rvalid) begin
          l2base_q <= mem_rdata[19:0];
          state    <= S_L2;
        end
        S_L2: if (mem_rvalid) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      c_val <= '0;
      rr    <= '0;
      for (int i = 0; i < SLOTS; i++) begin
        c_vpn[i] <= '0;
        c_ppn[i] <= '0;
      end
    end else if (leaf_fire) begin
      c_val[victim] <= 1'b1;
      c_vpn[victim] <= va_q[19:16];
      c_ppn[victim] <= mem_rdata[19:16];
      if (!has_free) rr <= (rr == IW'(SLOTS - 1)) ? '0 : rr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      xl_done <= 1'b0;
      xl_pa   <= '0;
    end else begin
      xl_done <= (accept && hit_any) || leaf_fire;
      if (accept && hit_any) xl_pa <= {hit_ppn, req_va[15:0]};
      else if (leaf_fire)    xl_pa <= {mem_rdata[19:16], va_q[15:0]};
    end
  end
endmodule

// File: rtl/vm_xlate_walker_sva.sv
module vm_xlate_walker_sva (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_req,
  input logic [19:0] mem_addr,
  input logic        mem_rvalid,
  input logic        xl_done,
  input logic        hit_any,
  input logic [1:0]  walk_st
);
  assert_read_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  assert_idle_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req);

  assert_done_when_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    xl_done |-> req_ready);

  assert_hit_no_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid && hit_any) |=> (xl_done && !mem_req));

  assert_leaf_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_st == 2'd2 && mem_rvalid) |=> (xl_done && req_ready));
endmodule

bind vm_xlate_walker vm_xlate_walker_sva u_sva (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
  .xl_done(xl_done), .hit_any(hit_any), .walk_st(state)
);

// File: tb/test_vm_xlate_walker.sv
`timescale 1ns/1ps
module test_vm_xlate_walker;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [19:0] req_va = '0;
  logic        req_ready, mem_req, xl_done;
  logic [19:0] mem_addr, xl_pa;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  always #5 clk = ~clk;

  vm_xlate_walker i_vm_xlate_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .req_ready(req_ready), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata),
    .xl_done(xl_done), .xl_pa(xl_pa)
  );

  int checks = 0, failures = 0, cycles = 0, walks = 0, dones = 0, lcnt = 0;
  int wcnt = 0, lat = 1;
  bit timed_out = 0;

  int          m_state = 0;
  logic [19:0] m_va = '0, m_l2 = '0, m_pa = '0;
  logic [3:0]  mv [4];
  logic [3:0]  mp [4];
  bit          mval [4];
  int          m_rr = 0;
  bit          m_done = 0, m_acc = 0, m_hit = 0;

  function automatic logic [31:0] memfn(input logic [19:0] a);
    if (a[19:4] == 16'h0100) return {12'hA5A, 20'h20000 + {10'b0, a[3:2], 8'h00}};
    return {12'h000, ({a[9:8], a[3:2]} ^ 4'h9), (16'h3C5A ^ a[15:0])};
  endfunction

  function automatic logic [19:0] exp_addr();
    if (m_state == 2) return m_l2 + {16'b0, m_va[17:16], 2'b00};
    return 20'h01000 + {16'b0, m_va[19:18], 2'b00};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h (cycle %0d)", tag, act, exp, cycles);
    end
  endtask

  task automatic model_edge();
    int found, slot;
    m_acc = 0; m_done = 0; m_hit = 0;
    case (m_state)
      0: if (req_valid) begin
        m_acc = 1; found = -1;
        for (int k = 0; k < 4; k++) if (mval[k] && mv[k] == req_va[19:16]) found = k;
        if (found >= 0) begin
          m_hit = 1; m_done = 1; m_pa = {mp[found], req_va[15:0]};
        end else begin
          m_state = 1; m_va = req_va; walks++;
        end
      end
      1: if (mem_rvalid) begin m_l2 = mem_rdata[19:0]; m_state = 2; end
      default: if (mem_rvalid) begin
        slot = -1;
        for (int k = 3; k >= 0; k--) if (!mval[k]) slot = k;
        if (slot < 0) begin slot = m_rr; m_rr = (m_rr + 1) % 4; end
        mval[slot] = 1; mv[slot] = m_va[19:16]; mp[slot] = mem_rdata[19:16];
        m_done = 1; m_pa = {mem_rdata[19:16], m_va[15:0]}; m_state = 0;
      end
    endcase
  endtask

  task automatic compare();
    chk(req_ready == (m_state == 0), "R9 ready", {31'b0, req_ready}, {31'b0, m_state == 0});
    chk(mem_req == (m_state != 0), "R5 mem_req", {31'b0, mem_req}, {31'b0, m_state != 0});
    if (m_state == 1) chk(mem_addr == exp_addr(), "R2 l1 addr", {12'b0, mem_addr}, {12'b0, exp_addr()});
    if (m_state == 2) chk(mem_addr == exp_addr(), "R3 l2 addr", {12'b0, mem_addr}, {12'b0, exp_addr()});
    chk(xl_done == m_done, "R10 done", {31'b0, xl_done}, {31'b0, m_done});
    if (m_done) chk(xl_pa == m_pa, "R4 pa", {12'b0, xl_pa}, {12'b0, m_pa});
    if (m_hit) chk(xl_done && !mem_req, "R6 hit", {30'b0, xl_done, mem_req}, 32'h2);
    if (m_done) dones++;
  endtask

  task automatic mem_drive();
    mem_rvalid = 1'b0;
    if (m_state != 0) begin
      if (wcnt >= lat) begin
        mem_rvalid = 1'b1; mem_rdata = memfn(exp_addr()); wcnt = 0;
        lcnt++; lat = (lcnt * 7 + 3) % 4;
      end else wcnt++;
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    cycles++;
    if (cycles > 50000) timed_out = 1;
    model_edge();
    @(negedge clk);
    compare();
    mem_drive();
  endtask

  task automatic run_seq(input logic [19:0] q [$], input bit hold);
    int i = 0, target;
    target = dones + q.size();
    req_valid = 1'b1; req_va = q[0];
    while (dones < target && !timed_out) begin
      cyc();
      if (m_acc) begin
        i++;
        if (i < q.size()) req_va = q[i];
        if (!hold || i >= q.size()) req_valid = 1'b0;
      end
      if (!hold && m_done && i < q.size()) req_valid = 1'b1;
    end
    req_valid = 1'b0;
    cyc();
  endtask

  initial begin
    int w0;
    for (int k = 0; k < 4; k++) begin mval[k] = 0; mv[k] = '0; mp[k] = '0; end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(req_ready && !mem_req && !xl_done, "R1 reset outputs",
        {29'b0, req_ready, mem_req, xl_done}, 32'h4);

    w0 = walks;
    run_seq('{20'hD180B}, 0);
    chk(walks - w0 == 1, "R1 first access walks", walks - w0, 1);
    chk(m_pa == 20'h4180B, "R4 known leaf frame", {12'b0, m_pa}, 32'h4180B);
    w0 = walks;
    run_seq('{20'hD0001}, 0);
    chk(walks - w0 == 0, "R6 repeat hits", walks - w0, 0);

    w0 = walks;
    run_seq('{20'h1AAAA, 20'h25555, 20'h30F0F}, 0);
    chk(walks - w0 == 3, "R7 fill walks", walks - w0, 3);
    w0 = walks;
    run_seq('{20'hD1234, 20'h10000, 20'h2FFFF, 20'h31111}, 0);
    chk(walks - w0 == 0, "R7 four resident", walks - w0, 0);

    w0 = walks;
    run_seq('{20'h5ABCD}, 0);
    run_seq('{20'h10001, 20'h20002, 20'h30003}, 0);
    chk(walks - w0 == 1, "R8 slot0 victim first", walks - w0, 1);
    w0 = walks;
    run_seq('{20'hD0000}, 0);
    chk(walks - w0 == 1, "R8 evicted page walks", walks - w0, 1);
    w0 = walks;
    run_seq('{20'h10000}, 0);
    chk(walks - w0 == 1, "R8 pointer advanced", walks - w0, 1);
    w0 = walks;
    run_seq('{20'h30000, 20'h5FFFF}, 0);
    chk(walks - w0 == 0, "R8 survivors hit", walks - w0, 0);

    w0 = walks;
    run_seq('{20'h84321, 20'h8FFFF, 20'h9C0DE, 20'h98765, 20'h9ABCD, 20'hE0101, 20'h84000}, 1);
    chk(walks - w0 == 3, "R9 back-to-back walks", walks - w0, 3);
    chk(!mem_req && req_ready, "R10 idle after stream", {30'b0, mem_req, req_ready}, 32'h1);

    if (timed_out) chk(1'b0, "R10 watchdog", cycles, 50000);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule